// File: doc/BRIEF.md
# Speculative Load Admission Gate

This block sits next to a small data cache and rules on every load that wants to fill or use a cache line. A load issued past an unresolved branch may touch the cache only if doing so leaves no trace that outlives the speculation. The load must displace no resident line. No other cache may be forced to change coherence state. The data read must be clean. Load-reserved accesses are never admitted while speculative, because taking a reservation on a line is observable. A speculative load that fails any of these tests is not sent to memory. It is held at the request port until its branch resolves and the requester re-presents it as non-speculative.

Each cache line carries a valid bit, a speculative bit and a 3-bit checkpoint tag. Checkpoints are handed out in wrapping order, and the gate tracks the oldest live one. All tag comparisons are made by age relative to that oldest checkpoint, so wraparound is harmless. A resolve event retires the oldest checkpoint: its lines become ordinary lines and the window moves forward by one. A squash at checkpoint N drops every speculative line tagged N or younger, and older speculation is kept. A remote snoop that hits a line still held by a speculative load flags only that line for retry and drops it.

The request port is valid/ready. A request stays asserted with stable fields until `req_ready` is high at a clock edge. A held request raises `stall` instead of `req_ready`. The grant and retry outputs are single-cycle pulses with no back-pressure, and the cache must take them as they come.

Top module: `spec_load_gate`

## Requirements
- R1: A speculative request that arrives with `victim_valid` high is not accepted and is not granted.
- R2: A speculative request that arrives with `coh_needed` high is not accepted and is not granted.
- R3: A speculative request that arrives with `line_dirty` high is not accepted and is not granted.
- R4: A speculative request with `req_lr` high is never granted. The same request without `req_spec` is granted.
- R5: A request that is not admitted is held: `stall` is 1 and `req_ready` is 0 for as long as it stays speculative. An admitted request has `req_ready` 1 and `stall` 0, and `grant_valid` pulses with `grant_line` in the following cycle. A non-speculative request is always admitted.
- R6: A snoop on a line whose valid and speculative bits are both set pulses `retry_valid` with that line in the next cycle and clears that line's valid bit. A snoop on an invalid or non-speculative line gives no retry and changes nothing.
- R7: A granted speculative load sets the line's bit in `valid_map` and in `spec_map`. A granted non-speculative load sets the `valid_map` bit and clears the `spec_map` bit.
- R8: A squash at checkpoint N clears the valid and speculative bits of every speculative line whose tag age (tag minus oldest, modulo 8) is at least the age of N. Every other line is left unchanged.
- R9: A resolve pulse clears the speculative bit of the lines tagged with the oldest checkpoint and advances the oldest checkpoint by one, modulo 8. The oldest checkpoint is 0 after reset.
- R10: A speculative request arriving in the same cycle as a squash that covers its checkpoint is accepted (`req_ready` 1) and dropped: no grant follows and no line changes. A request older than the squash point is still granted.
- R11: After reset, `valid_map`, `spec_map`, `grant_valid` and `retry_valid` are 0, and with no request both `req_ready` and `stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Request consumed this cycle (granted or dropped) |
| req_line | input | IDX_W | Cache line the load maps to |
| req_ckpt | input | CKPT_W | Checkpoint the load was issued under |
| req_spec | input | 1 | Load is past an unresolved branch |
| req_lr | input | 1 | Load-reserved access |
| victim_valid | input | 1 | Serving the load would displace a resident line |
| coh_needed | input | 1 | Another cache must change state to serve the load |
| line_dirty | input | 1 | Data the load reads is dirty |
| snoop_valid | input | 1 | Remote snoop present |
| snoop_line | input | IDX_W | Line the snoop hits |
| resolve_valid | input | 1 | Oldest checkpoint resolved as correct |
| squash_valid | input | 1 | Abandon speculation from a checkpoint on |
| squash_ckpt | input | CKPT_W | First abandoned checkpoint |
| stall | output | 1 | Request held by the speculation rules |
| grant_valid | output | 1 | Pulse: previous cycle's request granted |
| grant_line | output | IDX_W | Line of the granted request |
| retry_valid | output | 1 | Pulse: a speculative load must be retried |
| retry_line | output | IDX_W | Line to retry |
| valid_map | output | NUM_LINES | Per-line valid bits |
| spec_map | output | NUM_LINES | Per-line speculative bits |

## Verification
The hardest case to reach is a squash whose checkpoint window has wrapped, so that the oldest checkpoint is not zero and the doomed tags straddle the 7-to-0 boundary. The bench first moves the oldest checkpoint to 5 with resolve pulses. For each of the eight squash points it then fills all eight lines with consecutive tags starting at the oldest, and compares the surviving speculative bits with an age computed in the bench. The same-cycle squash and request race is driven by asserting both in one cycle, with request checkpoints just inside and just outside the squash point.

// File: rtl/spec_gate_pkg.sv
package spec_gate_pkg;
  // Outcome of the admission decision for the request in the current cycle
  typedef enum logic [1:0] {
    ADM_IDLE  = 2'd0,
    ADM_GRANT = 2'd1,
    ADM_HOLD  = 2'd2,
    ADM_DROP  = 2'd3
  } adm_e;
endpackage

// File: rtl/spec_ckpt_window.sv
module spec_ckpt_window #(
  parameter int CKPT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resolve_valid,
  output logic [CKPT_W-1:0] oldest
);
  logic [CKPT_W-1:0] oldest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) oldest_q <= '0;
    else if (resolve_valid) oldest_q <= oldest_q + 1'b1;
  end

  assign oldest = oldest_q;

  // R9: the window moves by exactly one per resolve
  assert_window_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_valid |=> (oldest_q - $past(oldest_q)) == CKPT_W'(1));
endmodule

// File: rtl/spec_admit.sv
module spec_admit
  import spec_gate_pkg::*;
#(
  parameter int CKPT_W = 3
) (
  input  logic              req_valid,
  input  logic              req_spec,
  input  logic              req_lr,
  input  logic              victim_valid,
  input  logic              coh_needed,
  input  logic              line_dirty,
  input  logic [CKPT_W-1:0] req_ckpt,
  input  logic              squash_valid,
  input  logic [CKPT_W-1:0] squash_ckpt,
  input  logic [CKPT_W-1:0] oldest,
  output adm_e              decision
);
  logic [CKPT_W-1:0] req_age;
  logic [CKPT_W-1:0] sq_age;
  logic              hazard;
  logic              doomed;

  always_comb begin
    req_age  = req_ckpt - oldest;
    sq_age   = squash_ckpt - oldest;
    hazard   = victim_valid | coh_needed | line_dirty | req_lr;
    doomed   = req_spec & squash_valid & (req_age >= sq_age);
    if (!req_valid)                decision = ADM_IDLE;
    else if (doomed)               decision = ADM_DROP;
    else if (req_spec && hazard)   decision = ADM_HOLD;
    else                           decision = ADM_GRANT;
  end
endmodule

// File: rtl/spec_line_table.sv
module spec_line_table #(
  parameter int NUM_LINES = 8,
  parameter int CKPT_W    = 3,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_line,
  input  logic                 wr_spec,
  input  logic [CKPT_W-1:0]    wr_ckpt,
  input  logic                 snoop_valid,
  input  logic [IDX_W-1:0]     snoop_line,
  input  logic                 resolve_valid,
  input  logic                 squash_valid,
  input  logic [CKPT_W-1:0]    squash_ckpt,
  input  logic [CKPT_W-1:0]    oldest,
  output logic                 retry_valid,
  output logic [IDX_W-1:0]     retry_line,
  output logic [NUM_LINES-1:0] valid_map,
  output logic [NUM_LINES-1:0] spec_map
);
  logic [CKPT_W-1:0] sq_age;
  assign sq_age = squash_ckpt - oldest;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic              v_q;
    logic              s_q;
    logic [CKPT_W-1:0] t_q;
    logic [CKPT_W-1:0] age;
    logic              wr_hit;
    logic              snoop_hit;
    logic              sq_hit;
    logic              res_hit;

    assign age       = t_q - oldest;
    assign wr_hit    = wr_en && (wr_line == IDX_W'(i));
    assign snoop_hit = snoop_valid && (snoop_line == IDX_W'(i)) && v_q && s_q;
    assign sq_hit    = squash_valid && s_q && (age >= sq_age);
    assign res_hit   = resolve_valid && s_q && (t_q == oldest);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        s_q <= 1'b0;
        t_q <= '0;
      end else begin
        if (res_hit) s_q <= 1'b0;
        if (snoop_hit || sq_hit) begin
          v_q <= 1'b0;
          s_q <= 1'b0;
        end
        if (wr_hit) begin
          v_q <= 1'b1;
          s_q <= wr_spec;
          t_q <= wr_ckpt;
        end
      end
    end

    assign valid_map[i] = v_q;
    assign spec_map[i]  = s_q;

    // R8: a squashed line is gone next cycle unless refilled
    assert_squash_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_hit && !wr_hit) |=> !v_q && !s_q);
    // R7: a speculative bit never stands on an invalid line
    assert_spec_implies_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s_q |-> v_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retry_valid <= 1'b0;
      retry_line  <= '0;
    end else begin
      retry_valid <= snoop_valid && valid_map[snoop_line] && spec_map[snoop_line];
      retry_line  <= snoop_line;
    end
  end
endmodule

// File: rtl/spec_load_gate.sv
module spec_load_gate
  import spec_gate_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CKPT_W    = 3,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [IDX_W-1:0]     req_line,
  input  logic [CKPT_W-1:0]    req_ckpt,
  input  logic                 req_spec,
  input  logic                 req_lr,
  input  logic                 victim_valid,
  input  logic                 coh_needed,
  input  logic                 line_dirty,
  input  logic                 snoop_valid,
  input  logic [IDX_W-1:0]     snoop_line,
  input  logic                 resolve_valid,
  input  logic                 squash_valid,
  input  logic [CKPT_W-1:0]    squash_ckpt,
  output logic                 stall,
  output logic                 grant_valid,
  output logic [IDX_W-1:0]     grant_line,
  output logic                 retry_valid,
  output logic [IDX_W-1:0]     retry_line,
  output logic [NUM_LINES-1:0] valid_map,
  output logic [NUM_LINES-1:0] spec_map
);
  logic [CKPT_W-1:0] oldest;
  adm_e              decision;
  logic              wr_en;

  spec_ckpt_window #(.CKPT_W(CKPT_W)) u_window (
    .clk(clk), .rst_n(rst_n), .resolve_valid(resolve_valid), .oldest(oldest)
  );

  spec_admit #(.CKPT_W(CKPT_W)) u_admit (
    .req_valid(req_valid), .req_spec(req_spec), .req_lr(req_lr),
    .victim_valid(victim_valid), .coh_needed(coh_needed), .line_dirty(line_dirty),
    .req_ckpt(req_ckpt), .squash_valid(squash_valid), .squash_ckpt(squash_ckpt),
    .oldest(oldest), .decision(decision)
  );

  assign wr_en     = (decision == ADM_GRANT);
  assign req_ready = (decision == ADM_GRANT) || (decision == ADM_DROP);
  assign stall     = (decision == ADM_HOLD);

  spec_line_table #(.NUM_LINES(NUM_LINES), .CKPT_W(CKPT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_line(req_line), .wr_spec(req_spec), .wr_ckpt(req_ckpt),
    .snoop_valid(snoop_valid), .snoop_line(snoop_line),
    .resolve_valid(resolve_valid), .squash_valid(squash_valid),
    .squash_ckpt(squash_ckpt), .oldest(oldest),
    .retry_valid(retry_valid), .retry_line(retry_line),
    .valid_map(valid_map), .spec_map(spec_map)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_line  <= '0;
    end else begin
      grant_valid <= wr_en;
      grant_line  <= req_line;
    end
  end

  assert_no_evict_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_spec && victim_valid) |=> !grant_valid);
  assert_no_coh_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_spec && coh_needed) |=> !grant_valid);
  assert_no_dirty_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_spec && line_dirty) |=> !grant_valid);
  assert_no_spec_lr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_spec && req_lr) |=> !grant_valid);
  assert_stall_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && req_ready));
  assert_snoop_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && valid_map[snoop_line] && spec_map[snoop_line])
      |=> retry_valid && retry_line == $past(snoop_line));
  assert_squash_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_spec && squash_valid &&
     (CKPT_W'(req_ckpt - oldest) >= CKPT_W'(squash_ckpt - oldest))) |=> !grant_valid);
endmodule

// File: tb/spec_load_gate_test.sv
`timescale 1ns/1ps
module spec_load_gate_test;
  localparam int NL = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_spec = 0, req_lr = 0;
  logic [2:0] req_line = '0, req_ckpt = '0, snoop_line = '0, squash_ckpt = '0;
  logic victim_valid = 0, coh_needed = 0, line_dirty = 0;
  logic snoop_valid = 0, resolve_valid = 0, squash_valid = 0;
  logic req_ready, stall, grant_valid, retry_valid;
  logic [2:0] grant_line, retry_line;
  logic [NL-1:0] valid_map, spec_map;

  int checks = 0;
  int fails = 0;
  int oldest_m = 0;

  always #2 clk = ~clk;

  spec_load_gate #(.NUM_LINES(NL), .CKPT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_ckpt(req_ckpt), .req_spec(req_spec), .req_lr(req_lr),
    .victim_valid(victim_valid), .coh_needed(coh_needed), .line_dirty(line_dirty),
    .snoop_valid(snoop_valid), .snoop_line(snoop_line), .resolve_valid(resolve_valid),
    .squash_valid(squash_valid), .squash_ckpt(squash_ckpt), .stall(stall),
    .grant_valid(grant_valid), .grant_line(grant_line), .retry_valid(retry_valid),
    .retry_line(retry_line), .valid_map(valid_map), .spec_map(spec_map)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    req_valid = 0; req_spec = 0; req_lr = 0;
    victim_valid = 0; coh_needed = 0; line_dirty = 0;
    snoop_valid = 0; resolve_valid = 0; squash_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_inputs();
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    oldest_m = 0;
  endtask

  // drive one granted-or-not request for a single cycle, outputs checked after the edge
  task automatic fill(input int line, input int ckpt, input logic spec);
    @(negedge clk);
    req_valid = 1; req_line = 3'(line); req_ckpt = 3'(ckpt); req_spec = spec;
    @(posedge clk); #1;
    clear_inputs();
  endtask

  task automatic resolve_once();
    @(negedge clk);
    resolve_valid = 1;
    @(posedge clk); #1;
    clear_inputs();
    oldest_m = (oldest_m + 1) % 8;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset();
    #1;
    check(valid_map == 0 && spec_map == 0, "R11 maps", int'(valid_map), 0);
    check(!grant_valid && !retry_valid, "R11 pulses", int'(grant_valid), 0);
    check(!req_ready && !stall, "R11 idle handshake", int'(req_ready), 0);

    // R1..R5 sweep over every combination of spec, lr and the three status inputs
    for (int m = 0; m < 32; m++) begin
      logic ok;
      string tag;
      ok = !m[4] || (m[3:0] == 0);
      tag = !m[4] ? "R5" : m[3] ? "R4" : m[2] ? "R1" : m[1] ? "R2" : m[0] ? "R3" : "R5";
      @(negedge clk);
      req_valid = 1; req_spec = m[4]; req_lr = m[3];
      victim_valid = m[2]; coh_needed = m[1]; line_dirty = m[0];
      req_line = 3'(m % 8); req_ckpt = 3'd0;
      #1;
      check(req_ready == ok && stall == !ok, tag, int'(req_ready), int'(ok));
      @(posedge clk); #1;
      clear_inputs();
      check(grant_valid == ok && (!ok || grant_line == 3'(m % 8)), tag, int'(grant_valid), int'(ok));
    end

    // R5 hold then release as non-speculative, R7 non-speculative fill
    do_reset();
    @(negedge clk);
    req_valid = 1; req_spec = 1; victim_valid = 1; req_line = 3'd6; req_ckpt = 3'd0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check(stall && !req_ready && !grant_valid, "R5 held", int'(stall), 1);
    end
    @(negedge clk);
    req_spec = 0;
    @(posedge clk); #1;
    clear_inputs();
    check(grant_valid && grant_line == 3'd6, "R5 release grant", int'(grant_line), 6);
    check(valid_map == 8'h40 && spec_map == 8'h00, "R7 nonspec fill", int'(spec_map), 0);

    // R7 speculative fill
    fill(2, 0, 1'b1);
    check(valid_map == 8'h44 && spec_map == 8'h04, "R7 spec fill", int'(spec_map), 4);

    // R6 snoop cases
    @(negedge clk); snoop_valid = 1; snoop_line = 3'd2;
    @(posedge clk); #1; clear_inputs();
    check(retry_valid && retry_line == 3'd2, "R6 retry pulse", int'(retry_valid), 1);
    check(valid_map == 8'h40 && spec_map == 8'h00, "R6 line dropped", int'(valid_map), 8'h40);
    @(negedge clk); snoop_valid = 1; snoop_line = 3'd5;
    @(posedge clk); #1; clear_inputs();
    check(!retry_valid, "R6 invalid line", int'(retry_valid), 0);
    @(negedge clk); snoop_valid = 1; snoop_line = 3'd6;
    @(posedge clk); #1; clear_inputs();
    check(!retry_valid && valid_map == 8'h40, "R6 nonspec line", int'(valid_map), 8'h40);

    // R8 squash at every checkpoint with the window wrapped (oldest = 5)
    do_reset();
    for (int k = 0; k < 5; k++) resolve_once();
    for (int n = 0; n < 8; n++) begin
      int sq_age;
      logic [NL-1:0] exp_s;
      for (int i = 0; i < 8; i++) fill(i, (oldest_m + i) % 8, 1'b1);
      check(spec_map == 8'hFF, "R7 full fill", int'(spec_map), 255);
      @(negedge clk); squash_valid = 1; squash_ckpt = 3'(n);
      @(posedge clk); #1; clear_inputs();
      sq_age = (n - oldest_m + 8) % 8;
      exp_s = '0;
      for (int i = 0; i < 8; i++) exp_s[i] = (i < sq_age);
      check(spec_map == exp_s && valid_map == exp_s, "R8 squash", int'(spec_map), int'(exp_s));
    end

    // R9 resolve walks the window across the wrap
    for (int i = 0; i < 8; i++) fill(i, (oldest_m + i) % 8, 1'b1);
    for (int k = 0; k < 8; k++) begin
      logic [NL-1:0] exp_s;
      resolve_once();
      exp_s = 8'hFF << (k + 1);
      check(spec_map == exp_s && valid_map == 8'hFF, "R9 resolve", int'(spec_map), int'(exp_s));
    end

    // R10 squash racing a request (oldest back at 5)
    @(negedge clk);
    squash_valid = 1; squash_ckpt = 3'((oldest_m + 3) % 8);
    req_valid = 1; req_spec = 1; req_line = 3'd3; req_ckpt = 3'((oldest_m + 4) % 8);
    #1;
    check(req_ready && !stall, "R10 dropped handshake", int'(req_ready), 1);
    @(posedge clk); #1; clear_inputs();
    check(!grant_valid && spec_map == 8'h00 && valid_map == 8'hFF, "R10 no grant", int'(grant_valid), 0);
    @(negedge clk);
    squash_valid = 1; squash_ckpt = 3'((oldest_m + 3) % 8);
    req_valid = 1; req_spec = 1; req_line = 3'd1; req_ckpt = 3'((oldest_m + 1) % 8);
    @(posedge clk); #1; clear_inputs();
    check(grant_valid && grant_line == 3'd1 && spec_map == 8'h02, "R10 older granted", int'(spec_map), 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule